// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register storage of a 32-bit processor datapath. The datapath always sees sixteen general registers, indices 0 to 15, plus a current status word and, in exception modes, a saved status word. Behind these sit 31 physical general registers and 6 physical status registers. The processor mode, held in the low five bits of the current status word, decides which physical copy each index reaches. A mode switch therefore exposes a fresh stack pointer and link register, and in the fast-interrupt mode also fresh copies of R8 to R12, without saving anything to memory.

The block has two registered read ports and one write port for general registers. The current status word has its own write port and is always visible. The saved status word of the current mode has a separate write port and a registered read output. All state changes on the rising clock edge. A read always returns the value held before any write in the same cycle.

Top module: `mode_banked_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, `cpsr_q` becomes 0x000000D3 (supervisor mode with both interrupt masks set), all five saved status copies become 0, and `spsr_q`, `ra_data` and `rb_data` become 0.
- R2: Each read port returns, after the clock edge that ends the cycle in which its index was presented, the register that index maps to in that cycle's mode; the two ports work independently.
- R3: If a read and a write target the same register in one cycle, the read returns the previous value, and the new value is returned from the next cycle on.
- R4: Indices 0 to 7 and index 15 reach one shared physical register each, in every mode.
- R5: Indices 8 to 12 are shared by all modes except fast-interrupt mode (code 0x11), which has five private registers in their place.
- R6: Indices 13 and 14 have a private pair in each of the fast-interrupt (0x11), interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes; user (0x10) and system (0x1F) modes share one pair.
- R7: The mode is `cpsr_q[4:0]`. Any code other than the seven listed in R6 selects the user/system registers and has no saved status word.
- R8: A write to the current status word changes the mode from the next cycle on; a general read or write in the same cycle still uses the old mode.
- R9: Each of the five exception modes has its own saved status word. A write through `spsr_we` changes only the current mode's copy, and `spsr_q` shows the current mode's copy one edge after the read cycle.
- R10: In user, system or an unlisted mode, `spsr_q` is 0 and `spsr_we` changes no saved status copy.
- R11: `cpsr_q` takes all 32 bits of `cpsr_wdata` at the edge where `cpsr_we` is high and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 32 | Read port A data, registered |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | Current status write data |
| cpsr_q | output | 32 | Current status word; bits 4:0 are the mode |
| spsr_we | input | 1 | Saved status write enable for the current mode |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_q | output | 32 | Saved status word of the current mode, registered |

## Verification
The bench writes different values to the same index in several modes and reads each one back from every other mode. A mapping that merges two banks shows a value from the wrong mode, and one that splits a shared register shows a stale value. Writing and reading one register in the same cycle exposes a design that forwards the new value. A status write made together with a stack-pointer write shows whether the mode change arrives a cycle early. Saved-status writes in user mode and in an unlisted mode catch a design that lets such a write land in some exception copy.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  // Bank groups; every value above BANK_USR owns a saved-status slot (value - 1)
  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  localparam int NUM_ARCH   = 16;
  localparam int FIQ_LO     = 8;
  localparam int FIQ_HI     = 12;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int NUM_EXC    = 5;
  localparam int FIQ_BASE   = NUM_ARCH;
  localparam int EXC_BASE   = FIQ_BASE + (FIQ_HI - FIQ_LO + 1);
  localparam int NUM_PHYS   = EXC_BASE + 2 * NUM_EXC;

  function automatic bank_e mode_to_bank(input logic [4:0] m);
    bank_e b;
    case (m)
      MODE_FIQ: b = BANK_FIQ;
      MODE_IRQ: b = BANK_IRQ;
      MODE_SVC: b = BANK_SVC;
      MODE_ABT: b = BANK_ABT;
      MODE_UND: b = BANK_UND;
      default:  b = BANK_USR;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PHYS_W = 5
) (
  input  logic [4:0]        mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);

  bank_e bank;
  int    ix;

  always_comb begin
    bank = mode_to_bank(mode);
    ix   = int'(idx);
    phys = PHYS_W'(ix);
    if (bank == BANK_FIQ && ix >= FIQ_LO && ix <= FIQ_HI) begin
      phys = PHYS_W'(FIQ_BASE + ix - FIQ_LO);
    end else if (bank != BANK_USR && (ix == SP_IDX || ix == LR_IDX)) begin
      phys = PHYS_W'(EXC_BASE + 2 * (int'(bank) - 1) + ((ix == LR_IDX) ? 1 : 0));
    end
  end

endmodule

// File: rtl/bankrf_mem.sv
module bankrf_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read of the pre-write contents
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/bankrf_psr.sv
module bankrf_psr
  import bankrf_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter logic [31:0] RESET_STATUS = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  output logic [DATA_W-1:0] spsr_q
);

  localparam int SLOT_W = $clog2(NUM_EXC);

  logic [NUM_EXC-1:0][DATA_W-1:0] spsr_bank;
  bank_e                          cur_bank;
  logic                           has_spsr;
  logic [SLOT_W-1:0]              slot;

  always_comb begin
    cur_bank = mode_to_bank(cpsr_q[4:0]);
    has_spsr = (cur_bank != BANK_USR);
    slot     = has_spsr ? SLOT_W'(int'(cur_bank) - 1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q    <= DATA_W'(RESET_STATUS);
      spsr_bank <= '0;
      spsr_q    <= '0;
    end else begin
      if (cpsr_we) begin
        cpsr_q <= cpsr_wdata;
      end
      if (spsr_we && has_spsr) begin
        spsr_bank[slot] <= spsr_wdata;
      end
      spsr_q <= has_spsr ? spsr_bank[slot] : '0;
    end
  end

  a_r11_cpsr_load: assert property (@(posedge clk) disable iff (rst)
    cpsr_we |=> cpsr_q == $past(cpsr_wdata));

  a_r11_cpsr_hold: assert property (@(posedge clk) disable iff (rst)
    !cpsr_we |=> $stable(cpsr_q));

  a_r10_no_spsr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !has_spsr |=> spsr_q == '0);

  a_r10_no_spsr_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (spsr_we && !has_spsr) |=> $stable(spsr_bank));

  a_r9_spsr_slot_written: assert property (@(posedge clk) disable iff (rst)
    (spsr_we && has_spsr) |=> spsr_bank[$past(slot)] == $past(spsr_wdata));

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import bankrf_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          IDX_W        = 4,
  parameter logic [31:0] RESET_STATUS = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_q
);

  localparam int PHYS_W = $clog2(NUM_PHYS);
  localparam int NUM_RD = 2;

  logic [4:0]        mode;
  logic [PHYS_W-1:0] wr_phys;
  logic [IDX_W-1:0]  rd_idx  [NUM_RD];
  logic [PHYS_W-1:0] rd_phys [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  assign mode      = cpsr_q[4:0];
  assign rd_idx[0] = ra_idx;
  assign rd_idx[1] = rb_idx;
  assign ra_data   = rd_data[0];
  assign rb_data   = rd_data[1];

  bankrf_psr #(.DATA_W(DATA_W), .RESET_STATUS(RESET_STATUS)) u_psr (
    .clk        (clk),
    .rst        (rst),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .cpsr_q     (cpsr_q),
    .spsr_q     (spsr_q)
  );

  bankrf_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_wmap (
    .mode (mode),
    .idx  (wr_idx),
    .phys (wr_phys)
  );

  // One memory copy per read port, all written together
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    bankrf_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_rmap (
      .mode (mode),
      .idx  (rd_idx[p]),
      .phys (rd_phys[p])
    );

    bankrf_mem #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS), .ADDR_W(PHYS_W)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .waddr (wr_phys),
      .wdata (wr_data),
      .raddr (rd_phys[p]),
      .rdata (rd_data[p])
    );
  end

  a_r4_low_index_shared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx < IDX_W'(FIQ_LO) || wr_idx == IDX_W'(15)))
      |-> wr_phys == PHYS_W'(wr_idx));

  a_r5_fiq_private_range: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == MODE_FIQ && wr_idx >= IDX_W'(FIQ_LO) && wr_idx <= IDX_W'(FIQ_HI))
      |-> (wr_phys >= PHYS_W'(FIQ_BASE) && wr_phys < PHYS_W'(EXC_BASE)));

  a_r6_user_pair_shared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (mode == MODE_USR || mode == MODE_SYS) && wr_idx >= IDX_W'(SP_IDX))
      |-> wr_phys == PHYS_W'(wr_idx));

endmodule

// File: tb/mode_banked_regfile_tb.sv
module mode_banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [31:0] ra_data, rb_data, cpsr_q, spsr_q;
  logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
  logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                         M_SVC = 5'h13, M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;

  always #2 clk = ~clk;

  mode_banked_regfile u_dut (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_q(spsr_q)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    cpsr_we = 1'b1; cpsr_wdata = {24'h0, 3'b110, m};
    tick();
    cpsr_we = 1'b0;
  endtask

  task automatic wr_gpr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_both(input logic [3:0] ia, input logic [3:0] ib,
                         output logic [31:0] da, output logic [31:0] db);
    ra_idx = ia; rb_idx = ib;
    tick();
    da = ra_data; db = rb_data;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R1 cpsr", cpsr_q, 32'h0000_00D3);
    check("R1 spsr", spsr_q, 32'h0);
    check("R1 ra", ra_data, 32'h0);
    check("R1 rb", rb_data, 32'h0);
    rst = 1'b0;
  endtask

  // R4 and R2: low registers and R15 are seen by every mode, on both ports
  task automatic t_shared_low();
    logic [31:0] a, b;
    logic [4:0] modes [3] = '{M_USR, M_FIQ, M_UND};
    set_mode(M_SVC);
    for (int i = 0; i < 8; i++) wr_gpr(4'(i), 32'h100 + i);
    wr_gpr(4'd15, 32'h10F);
    foreach (modes[k]) begin
      set_mode(modes[k]);
      for (int i = 0; i < 8; i += 2) begin
        rd_both(4'(i), 4'(i + 1), a, b);
        check("R4 R2 port A", a, 32'h100 + i);
        check("R4 R2 port B", b, 32'h101 + i);
      end
      rd_both(4'd15, 4'd0, a, b);
      check("R4 r15", a, 32'h10F);
    end
  endtask

  task automatic t_fiq_high();
    logic [31:0] a, b;
    set_mode(M_USR);
    for (int i = 8; i <= 12; i++) wr_gpr(4'(i), 32'hA0 + i);
    set_mode(M_FIQ);
    for (int i = 8; i <= 12; i++) wr_gpr(4'(i), 32'hF0 + i);
    for (int i = 8; i <= 12; i++) begin
      rd_both(4'(i), 4'(i), a, b);
      check("R5 fiq private", a, 32'hF0 + i);
    end
    set_mode(M_IRQ);
    for (int i = 8; i <= 12; i++) begin
      rd_both(4'(i), 4'd0, a, b);
      check("R5 irq sees shared", a, 32'hA0 + i);
    end
    set_mode(M_SYS);
    rd_both(4'd8, 4'd12, a, b);
    check("R5 sys r8", a, 32'hA8);
    check("R5 sys r12", b, 32'hAC);
  endtask

  task automatic t_sp_lr();
    logic [31:0] a, b;
    logic [4:0] modes [6] = '{M_USR, M_SVC, M_ABT, M_UND, M_IRQ, M_FIQ};
    foreach (modes[k]) begin
      set_mode(modes[k]);
      wr_gpr(4'd13, 32'h1300 + k);
      wr_gpr(4'd14, 32'h1400 + k);
    end
    foreach (modes[k]) begin
      set_mode(modes[k]);
      rd_both(4'd13, 4'd14, a, b);
      check("R6 sp", a, 32'h1300 + k);
      check("R6 lr", b, 32'h1400 + k);
    end
    set_mode(M_SYS);
    rd_both(4'd13, 4'd14, a, b);
    check("R6 sys sp", a, 32'h1300);
    check("R6 sys lr", b, 32'h1400);
  endtask

  task automatic t_same_cycle();
    set_mode(M_USR);
    wr_gpr(4'd3, 32'h1111_1111);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h2222_2222; ra_idx = 4'd3;
    tick();
    wr_en = 1'b0;
    check("R3 old value", ra_data, 32'h1111_1111);
    tick();
    check("R3 new value", ra_data, 32'h2222_2222);
  endtask

  task automatic t_mode_delay();
    logic [31:0] a, b;
    set_mode(M_USR);
    cpsr_we = 1'b1; cpsr_wdata = {24'h0, 3'b110, M_SVC};
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hDEAD_0013; ra_idx = 4'd13;
    tick();
    cpsr_we = 1'b0; wr_en = 1'b0;
    check("R8 read uses old mode", ra_data, 32'h1300);
    rd_both(4'd13, 4'd14, a, b);
    check("R8 svc sp untouched", a, 32'h1301);
    set_mode(M_USR);
    rd_both(4'd13, 4'd14, a, b);
    check("R8 write hit old bank", a, 32'hDEAD_0013);
  endtask

  task automatic t_invalid_mode();
    logic [31:0] a, b;
    set_mode(5'h00);
    rd_both(4'd13, 4'd10, a, b);
    check("R7 unlisted sp", a, 32'hDEAD_0013);
    check("R7 unlisted r10", b, 32'hAA);
    check("R7 unlisted spsr", spsr_q, 32'h0);
  endtask

  task automatic t_spsr();
    logic [4:0] modes [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    foreach (modes[k]) begin
      set_mode(modes[k]);
      spsr_we = 1'b1; spsr_wdata = 32'h5000 + k;
      tick();
      spsr_we = 1'b0;
    end
    foreach (modes[k]) begin
      set_mode(modes[k]);
      tick();
      check("R9 spsr copy", spsr_q, 32'h5000 + k);
    end
  endtask

  task automatic t_spsr_none();
    logic [4:0] modes [3] = '{M_USR, M_SYS, 5'h05};
    foreach (modes[k]) begin
      set_mode(modes[k]);
      spsr_we = 1'b1; spsr_wdata = 32'hBAD0 + k;
      tick();
      spsr_we = 1'b0;
      tick();
      check("R10 spsr reads zero", spsr_q, 32'h0);
    end
    set_mode(M_SVC);
    tick();
    check("R10 svc spsr unchanged", spsr_q, 32'h5002);
    set_mode(M_FIQ);
    tick();
    check("R10 fiq spsr unchanged", spsr_q, 32'h5000);
  endtask

  task automatic t_cpsr();
    cpsr_we = 1'b1; cpsr_wdata = 32'hF000_00D7;
    tick();
    cpsr_we = 1'b0;
    check("R11 cpsr loaded", cpsr_q, 32'hF000_00D7);
    cpsr_wdata = 32'h0;
    tick();
    check("R11 cpsr holds", cpsr_q, 32'hF000_00D7);
    check("R11 abort spsr visible", spsr_q, 32'h5003);
  endtask

  initial begin
    t_reset();
    t_shared_low();
    t_fiq_high();
    t_sp_lr();
    t_same_cycle();
    t_mode_delay();
    t_invalid_mode();
    t_spsr();
    t_spsr_none();
    t_cpsr();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule